// File: doc/BRIEF.md
# Interrupt Acceptance and Exception Sequencer

This block sits beside a processor pipeline and decides when an exception is taken. It collects reset and non-maskable interrupt requests as pending flags, OR-collects maskable interrupt level bits into a pending vector, and takes a synchronous exception raised by the pipeline. Each cycle it picks at most one event by fixed priority. When it takes one, it updates the status, cause and EPC registers and emits a one-cycle take strobe together with the new program counter.

The status register holds a three-level stack of interrupt-enable and kernel-mode bit pairs. Taking an exception pushes the stack. A return-from-exception strobe pops it. A maskable interrupt that is disabled or masked is not lost: it stays pending and is checked again every cycle. A status load port lets the pipeline write the status register, for example to set the mask or the enable bit.

Top module: `trap_sequencer`

## Requirements
- R1: After a synchronous reset the outputs are: status = 0x00400000 (only the boot-vector bit 22 set), cause = 0, EPC = 0, take strobe = 0 and new PC = 0.
- R2: Maskable level strobes are OR-accumulated into a pending vector. Bits arriving on separate cycles combine. The whole vector clears when a maskable interrupt is delivered.
- R3: A maskable interrupt is taken only when status bit 0 is 1 and some pending bit i is matched by status mask bit 8+i. Otherwise the request stays pending and is taken later, once the status allows it.
- R4: On entry, status bits [3:0] move to [5:2], bits [1:0] become 0, and all bits above 5 are unchanged.
- R5: On entry, the exception code goes to cause bits [6:2]. The code is 0 for a maskable interrupt, 31 for reset and NMI, and the supplied 5-bit code for a synchronous exception. Cause bits [30:7] and [1:0] keep their value.
- R6: Cause bit 31 is written with the delay-slot flag. EPC becomes PC-4 when the flag is set and PC otherwise.
- R7: Maskable interrupts and synchronous exceptions vector to 0xBFC00180 when status bit 22 is 1, and to 0x80000080 when it is 0.
- R8: A return strobe copies status bits [5:2] to [3:0] and leaves bits [5:4] and everything above unchanged.
- R9: Priority is reset > NMI > synchronous exception > maskable interrupt. One event is taken per cycle, and only the served pending flag clears.
- R10: Reset and NMI requests always vector to 0xBFC00000.
- R11: The take strobe, the new PC and the register updates appear one clock after the decision. A status load is applied when neither an exception nor a return occurs in that cycle. A return is ignored in a cycle that takes an exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reset_req_i | input | 1 | Soft-reset request strobe |
| nmi_req_i | input | 1 | Non-maskable interrupt strobe |
| lvl_req_i | input | 8 | Maskable interrupt level bits, OR-accumulated |
| pc_i | input | 32 | PC of the current instruction |
| in_delay_i | input | 1 | Current instruction sits in a branch delay slot |
| sync_exc_i | input | 1 | Synchronous exception request |
| sync_code_i | input | 5 | Code of the synchronous exception |
| rfe_i | input | 1 | Return-from-exception strobe |
| sr_wr_i | input | 1 | Status load enable |
| sr_wdata_i | input | 32 | Status load value |
| status_o | output | 32 | Status register |
| cause_o | output | 32 | Cause register |
| epc_o | output | 32 | Exception PC register |
| take_o | output | 1 | One-cycle strobe: exception taken |
| new_pc_o | output | 32 | Vector address of the taken exception |

## Verification
Synchronous exceptions are applied with the boot-vector bit both set and clear, and both inside and outside a delay slot. This separates the two general vectors and the two EPC forms. Maskable requests are raised first with the enable bit clear and then with a non-matching mask bit, and are enabled afterwards. This shows that a request is retained rather than dropped, and that separately arriving bits accumulate. Reset, NMI and a level request raised in the same cycle, and a synchronous exception arriving while a level request is pending, expose the priority order. Return strobes on stacks with distinct bit patterns show which status bits move and which stay.

// File: rtl/trap_pkg.sv
package trap_pkg;

  typedef enum logic [2:0] {
    SRC_NONE,
    SRC_RESET,
    SRC_NMI,
    SRC_SYNC,
    SRC_LEVEL
  } trap_src_e;

  localparam int CODE_W = 5;
  localparam logic [CODE_W-1:0] CODE_INTR = 5'd0;
  localparam logic [CODE_W-1:0] CODE_HARD = 5'd31;

endpackage

// File: rtl/trap_pending.sv
module trap_pending #(
  parameter int LVL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rst_req_i,
  input  logic             nmi_req_i,
  input  logic [LVL_W-1:0] lvl_req_i,
  input  logic             clr_rst_i,
  input  logic             clr_nmi_i,
  input  logic             clr_lvl_i,
  output logic             pend_rst_o,
  output logic             pend_nmi_o,
  output logic [LVL_W-1:0] pend_lvl_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_rst_o <= 1'b0;
      pend_nmi_o <= 1'b0;
      pend_lvl_o <= '0;
    end else begin
      pend_rst_o <= (pend_rst_o & ~clr_rst_i) | rst_req_i;
      pend_nmi_o <= (pend_nmi_o & ~clr_nmi_i) | nmi_req_i;
      pend_lvl_o <= (clr_lvl_i ? '0 : pend_lvl_o) | lvl_req_i;
    end
  end

endmodule

// File: rtl/trap_arbiter.sv
module trap_arbiter
  import trap_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          LVL_W    = 8,
  parameter int          MASK_LSB = 8,
  parameter int          BEV_BIT  = 22,
  parameter logic [31:0] HARD_VEC = 32'hBFC0_0000,
  parameter logic [31:0] BOOT_VEC = 32'hBFC0_0180,
  parameter logic [31:0] RAM_VEC  = 32'h8000_0080
) (
  input  logic              pend_rst_i,
  input  logic              pend_nmi_i,
  input  logic [LVL_W-1:0]  pend_lvl_i,
  input  logic              sync_exc_i,
  input  logic [CODE_W-1:0] sync_code_i,
  input  logic [XLEN-1:0]   status_i,
  output trap_src_e         src_o,
  output logic [CODE_W-1:0] code_o,
  output logic [XLEN-1:0]   vector_o,
  output logic              take_o
);

  logic [LVL_W-1:0] lvl_hit;
  logic             lvl_ok;

  for (genvar i = 0; i < LVL_W; i++) begin : g_mask
    assign lvl_hit[i] = pend_lvl_i[i] & status_i[MASK_LSB + i];
  end

  assign lvl_ok = status_i[0] & (|lvl_hit);

  always_comb begin
    src_o  = SRC_NONE;
    code_o = CODE_INTR;
    if (pend_rst_i) begin
      src_o  = SRC_RESET;
      code_o = CODE_HARD;
    end else if (pend_nmi_i) begin
      src_o  = SRC_NMI;
      code_o = CODE_HARD;
    end else if (sync_exc_i) begin
      src_o  = SRC_SYNC;
      code_o = sync_code_i;
    end else if (lvl_ok) begin
      src_o  = SRC_LEVEL;
      code_o = CODE_INTR;
    end
  end

  assign take_o = (src_o != SRC_NONE);

  always_comb begin
    if (src_o == SRC_RESET || src_o == SRC_NMI)
      vector_o = XLEN'(HARD_VEC);
    else if (status_i[BEV_BIT])
      vector_o = XLEN'(BOOT_VEC);
    else
      vector_o = XLEN'(RAM_VEC);
  end

endmodule

// File: rtl/trap_csr.sv
module trap_csr
  import trap_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int BEV_BIT = 22
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [XLEN-1:0]   vector_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic              in_delay_i,
  input  logic              rfe_i,
  input  logic              sr_wr_i,
  input  logic [XLEN-1:0]   sr_wdata_i,
  output logic [XLEN-1:0]   status_o,
  output logic [XLEN-1:0]   cause_o,
  output logic [XLEN-1:0]   epc_o,
  output logic              take_o,
  output logic [XLEN-1:0]   new_pc_o
);

  localparam logic [XLEN-1:0] SR_RST = XLEN'(1) << BEV_BIT;

  logic [XLEN-1:0] sr_push;
  logic [XLEN-1:0] sr_pop;
  logic [XLEN-1:0] cause_nxt;

  assign sr_push   = {status_o[XLEN-1:6], status_o[3:0], 2'b00};
  assign sr_pop    = {status_o[XLEN-1:4], status_o[5:2]};
  assign cause_nxt = {in_delay_i, cause_o[XLEN-2:7], code_i, cause_o[1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      status_o <= SR_RST;
      cause_o  <= '0;
      epc_o    <= '0;
      take_o   <= 1'b0;
      new_pc_o <= '0;
    end else begin
      take_o <= take_i;
      if (take_i) begin
        status_o <= sr_push;
        cause_o  <= cause_nxt;
        epc_o    <= in_delay_i ? (pc_i - XLEN'(4)) : pc_i;
        new_pc_o <= vector_i;
      end else if (rfe_i) begin
        status_o <= sr_pop;
      end else if (sr_wr_i) begin
        status_o <= sr_wdata_i;
      end
    end
  end

endmodule

// File: rtl/trap_sequencer.sv
module trap_sequencer
  import trap_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          LVL_W    = 8,
  parameter int          MASK_LSB = 8,
  parameter int          BEV_BIT  = 22,
  parameter logic [31:0] HARD_VEC = 32'hBFC0_0000,
  parameter logic [31:0] BOOT_VEC = 32'hBFC0_0180,
  parameter logic [31:0] RAM_VEC  = 32'h8000_0080
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reset_req_i,
  input  logic              nmi_req_i,
  input  logic [LVL_W-1:0]  lvl_req_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic              in_delay_i,
  input  logic              sync_exc_i,
  input  logic [4:0]        sync_code_i,
  input  logic              rfe_i,
  input  logic              sr_wr_i,
  input  logic [XLEN-1:0]   sr_wdata_i,
  output logic [XLEN-1:0]   status_o,
  output logic [XLEN-1:0]   cause_o,
  output logic [XLEN-1:0]   epc_o,
  output logic              take_o,
  output logic [XLEN-1:0]   new_pc_o
);

  logic              pend_rst;
  logic              pend_nmi;
  logic [LVL_W-1:0]  pend_lvl;
  trap_src_e         dec_src;
  logic [CODE_W-1:0] dec_code;
  logic [XLEN-1:0]   dec_vec;
  logic              dec_take;

  trap_pending #(.LVL_W(LVL_W)) u_pend (
    .clk        (clk),
    .rst        (rst),
    .rst_req_i  (reset_req_i),
    .nmi_req_i  (nmi_req_i),
    .lvl_req_i  (lvl_req_i),
    .clr_rst_i  (dec_src == SRC_RESET),
    .clr_nmi_i  (dec_src == SRC_NMI),
    .clr_lvl_i  (dec_src == SRC_LEVEL),
    .pend_rst_o (pend_rst),
    .pend_nmi_o (pend_nmi),
    .pend_lvl_o (pend_lvl)
  );

  trap_arbiter #(
    .XLEN(XLEN), .LVL_W(LVL_W), .MASK_LSB(MASK_LSB), .BEV_BIT(BEV_BIT),
    .HARD_VEC(HARD_VEC), .BOOT_VEC(BOOT_VEC), .RAM_VEC(RAM_VEC)
  ) u_arb (
    .pend_rst_i  (pend_rst),
    .pend_nmi_i  (pend_nmi),
    .pend_lvl_i  (pend_lvl),
    .sync_exc_i  (sync_exc_i),
    .sync_code_i (sync_code_i),
    .status_i    (status_o),
    .src_o       (dec_src),
    .code_o      (dec_code),
    .vector_o    (dec_vec),
    .take_o      (dec_take)
  );

  trap_csr #(.XLEN(XLEN), .BEV_BIT(BEV_BIT)) u_csr (
    .clk        (clk),
    .rst        (rst),
    .take_i     (dec_take),
    .code_i     (dec_code),
    .vector_i   (dec_vec),
    .pc_i       (pc_i),
    .in_delay_i (in_delay_i),
    .rfe_i      (rfe_i),
    .sr_wr_i    (sr_wr_i),
    .sr_wdata_i (sr_wdata_i),
    .status_o   (status_o),
    .cause_o    (cause_o),
    .epc_o      (epc_o),
    .take_o     (take_o),
    .new_pc_o   (new_pc_o)
  );

endmodule

// File: rtl/trap_sequencer_chk.sv
module trap_sequencer_chk #(
  parameter int          XLEN     = 32,
  parameter int          BEV_BIT  = 22,
  parameter logic [31:0] HARD_VEC = 32'hBFC0_0000,
  parameter logic [31:0] BOOT_VEC = 32'hBFC0_0180,
  parameter logic [31:0] RAM_VEC  = 32'h8000_0080
) (
  input logic            clk,
  input logic            rst,
  input logic            sync_exc_i,
  input logic            rfe_i,
  input logic            pend_rst,
  input logic            pend_nmi,
  input logic            dec_take,
  input logic [XLEN-1:0] status_o,
  input logic [XLEN-1:0] cause_o,
  input logic            take_o,
  input logic [XLEN-1:0] new_pc_o
);

  // R4
  stack_push_chk: assert property (@(posedge clk) disable iff (rst)
    take_o |-> (status_o[5:2] == $past(status_o[3:0])) && (status_o[1:0] == 2'b00)
               && (status_o[XLEN-1:6] == $past(status_o[XLEN-1:6])));

  // R8
  stack_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (rfe_i && !dec_take) |=> (status_o[3:0] == $past(status_o[5:2]))
                             && (status_o[XLEN-1:4] == $past(status_o[XLEN-1:4])));

  // R10
  hard_vec_chk: assert property (@(posedge clk) disable iff (rst)
    (take_o && cause_o[6:2] == 5'd31) |-> (new_pc_o == XLEN'(HARD_VEC)));

  // R7
  gen_vec_chk: assert property (@(posedge clk) disable iff (rst)
    (take_o && cause_o[6:2] != 5'd31) |->
      (new_pc_o == (status_o[BEV_BIT] ? XLEN'(BOOT_VEC) : XLEN'(RAM_VEC))));

  // R5
  cause_keep_chk: assert property (@(posedge clk) disable iff (rst)
    take_o |-> (cause_o[XLEN-2:7] == $past(cause_o[XLEN-2:7])));

  // R3
  ie_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (!status_o[0] && !sync_exc_i && !pend_rst && !pend_nmi) |=> !take_o);

endmodule

bind trap_sequencer trap_sequencer_chk #(
  .XLEN(XLEN), .BEV_BIT(BEV_BIT),
  .HARD_VEC(HARD_VEC), .BOOT_VEC(BOOT_VEC), .RAM_VEC(RAM_VEC)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .sync_exc_i (sync_exc_i),
  .rfe_i      (rfe_i),
  .pend_rst   (pend_rst),
  .pend_nmi   (pend_nmi),
  .dec_take   (dec_take),
  .status_o   (status_o),
  .cause_o    (cause_o),
  .take_o     (take_o),
  .new_pc_o   (new_pc_o)
);

// File: tb/trap_sequencer_tb.sv
`timescale 1ns/1ps
module trap_sequencer_tb;

  typedef struct {
    logic [31:0] vec;
    logic [31:0] sr;
    logic [31:0] cause;
    logic [31:0] epc;
    string       req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reset_req_i = 1'b0;
  logic        nmi_req_i = 1'b0;
  logic [7:0]  lvl_req_i = '0;
  logic [31:0] pc_i = '0;
  logic        in_delay_i = 1'b0;
  logic        sync_exc_i = 1'b0;
  logic [4:0]  sync_code_i = '0;
  logic        rfe_i = 1'b0;
  logic        sr_wr_i = 1'b0;
  logic [31:0] sr_wdata_i = '0;
  logic [31:0] status_o, cause_o, epc_o, new_pc_o;
  logic        take_o;

  exp_t        q[$];
  int          checks = 0;
  int          fails = 0;
  logic [31:0] m_sr = 32'h0040_0000;
  logic [31:0] m_cause = '0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  trap_sequencer u_dut (
    .clk(clk), .rst(rst), .reset_req_i(reset_req_i), .nmi_req_i(nmi_req_i),
    .lvl_req_i(lvl_req_i), .pc_i(pc_i), .in_delay_i(in_delay_i),
    .sync_exc_i(sync_exc_i), .sync_code_i(sync_code_i), .rfe_i(rfe_i),
    .sr_wr_i(sr_wr_i), .sr_wdata_i(sr_wdata_i), .status_o(status_o),
    .cause_o(cause_o), .epc_o(epc_o), .take_o(take_o), .new_pc_o(new_pc_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // expected entry for an exception the driver has just caused
  task automatic push_exp(input string req, input logic [4:0] code, input bit hard);
    exp_t e;
    if (hard) e.vec = 32'hBFC0_0000;
    else      e.vec = m_sr[22] ? 32'hBFC0_0180 : 32'h8000_0080;
    m_sr    = {m_sr[31:6], m_sr[3:0], 2'b00};
    m_cause = {in_delay_i, m_cause[30:7], code, m_cause[1:0]};
    e.sr    = m_sr;
    e.cause = m_cause;
    e.epc   = in_delay_i ? pc_i - 32'd4 : pc_i;
    e.req   = req;
    q.push_back(e);
  endtask

  task automatic sr_write(input logic [31:0] v);
    sr_wr_i = 1'b1; sr_wdata_i = v; m_sr = v;
    tick(1);
    sr_wr_i = 1'b0;
  endtask

  task automatic sync_exc(input string req, input logic [4:0] code,
                          input logic [31:0] pc, input bit dly);
    pc_i = pc; in_delay_i = dly;
    sync_exc_i = 1'b1; sync_code_i = code;
    push_exp(req, code, 1'b0);
    tick(1);
    sync_exc_i = 1'b0;
  endtask

  task automatic pulse_lvl(input logic [7:0] b);
    lvl_req_i = b;
    tick(1);
    lvl_req_i = '0;
  endtask

  task automatic do_rfe();
    rfe_i = 1'b1;
    m_sr = {m_sr[31:4], m_sr[5:2]};
    tick(1);
    rfe_i = 1'b0;
  endtask

  task automatic drained(input string req);
    tick(4);
    chk(req, "pending expected events", q.size(), 0);
  endtask

  // monitor: compares every take against the scoreboard
  always @(negedge clk) begin
    if (!rst && take_o) begin
      if (q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R3 unexpected take: actual vec %h expected none", new_pc_o);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(e.req, "new pc", new_pc_o, e.vec);
        chk(e.req, "status", status_o, e.sr);
        chk(e.req, "cause", cause_o, e.cause);
        chk(e.req, "epc", epc_o, e.epc);
      end
    end
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst = 1'b0;
    // R1 reset state
    chk("R1", "status", status_o, 32'h0040_0000);
    chk("R1", "cause", cause_o, 32'h0);
    chk("R1", "epc", epc_o, 32'h0);
    chk("R1", "take", {31'b0, take_o}, 32'h0);
    chk("R1", "new pc", new_pc_o, 32'h0);

    // R7 R5 R11: sync exception, boot vector bit set, one-cycle latency
    sync_exc("R7", 5'd5, 32'h0000_0100, 1'b0);
    drained("R11");

    // R6 R4: delay slot, boot vector bit clear
    sr_write(32'h0000_FF03);
    chk("R11", "status load", status_o, 32'h0000_FF03);
    sync_exc("R6", 5'd9, 32'h0000_2004, 1'b1);
    drained("R6");

    // R8: return restores bits [3:0] and keeps [5:4]
    sr_write(32'h0000_FF3C);
    do_rfe();
    chk("R8", "status after return", status_o, 32'h0000_FF3F);
    do_rfe();
    chk("R8", "status after second return", status_o, 32'h0000_FF3F);

    // R3: masked by enable bit, retained, taken when enabled
    pc_i = 32'h0000_0400; in_delay_i = 1'b0;
    sr_write(32'h0000_FF00);
    pulse_lvl(8'h04);
    drained("R3");
    sr_write(32'h0000_FF01);
    push_exp("R3", 5'd0, 1'b0);
    drained("R3");

    // R2: accumulation across strobes, clear on delivery
    sr_write(32'h0000_0401);
    pulse_lvl(8'h01);
    drained("R2");
    pulse_lvl(8'h04);
    push_exp("R2", 5'd0, 1'b0);
    drained("R2");
    sr_write(32'h0000_0101);
    drained("R2");
    chk("R2", "status unchanged after clear", status_o, 32'h0000_0101);

    // R9 R10: reset, NMI and level in one cycle
    sr_write(32'h0000_FF01);
    pc_i = 32'h0000_0500;
    reset_req_i = 1'b1; nmi_req_i = 1'b1; lvl_req_i = 8'h01;
    push_exp("R10", 5'd31, 1'b1);
    push_exp("R9", 5'd31, 1'b1);
    tick(1);
    reset_req_i = 1'b0; nmi_req_i = 1'b0; lvl_req_i = '0;
    drained("R9");
    sr_write(32'h0000_FF01);
    push_exp("R9", 5'd0, 1'b0);
    drained("R9");

    // R9 R11: sync exception beats a pending maskable request
    sr_write(32'h0000_FF01);
    pc_i = 32'h0000_0600;
    pulse_lvl(8'h02);
    lvl_req_i = '0;
    sync_exc("R9", 5'd12, 32'h0000_0600, 1'b0);
    drained("R9");
    sr_write(32'h0000_FF01);
    push_exp("R3", 5'd0, 1'b0);
    drained("R3");

    // R11: return in the same cycle as an exception is ignored
    sr_write(32'h0000_FF3C);
    rfe_i = 1'b1;
    sync_exc("R11", 5'd4, 32'h0000_0700, 1'b0);
    rfe_i = 1'b0;
    drained("R11");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule